// File: doc/BRIEF.md
# Pulse-count carrier detector

This block decides whether a usable receive carrier is present on a half-duplex line. A level comparator in front of it outputs high while the filtered receive signal is above the detection threshold. The block synchronizes that comparator output to its own clock, treats each rising edge as one pulse, and raises a carrier-detect flag once enough back-to-back pulses have arrived. A gap timer measures the time since the last pulse. If no new pulse arrives within the allowed window, the flag drops and counting starts over from zero.

While the local side is transmitting, signalled by the active-low request-to-send input being low, the detector is held quiet. The flag, the pulse count and the gap timer are all cleared. At the default clock of 460.8 kHz, the default window of 1152 clocks is 2.5 ms. A 1200 Hz tone gives one pulse every 384 clocks and a 2200 Hz tone gives one every 209 clocks, so either tone keeps the flag up.

The control is a four-state machine:

- `CS_TX`: transmitting. Entered from any state whenever request-to-send is low. It leaves to `CS_IDLE` once request-to-send is high.
- `CS_IDLE`: no pulses collected. The first edge moves it to `CS_GATHER` with a count of one.
- `CS_GATHER`: collecting a run. The edge that completes the run moves it to `CS_LOCK`. A gap timeout sends it back to `CS_IDLE`.
- `CS_LOCK`: flag high. A gap timeout sends it to `CS_IDLE`.

Synchronous reset puts the machine in `CS_IDLE`.

Top module: `carrier_sense`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flag is low after that edge, and any partly collected run is discarded.
- R2: The flag rises exactly SYNC_STAGES+1 clocks after the input edge that completes a run of PULSE_RUN consecutive rising edges on `cmp_i`. After PULSE_RUN-1 edges it is still low.
- R3: Only low-to-high transitions of `cmp_i` count as pulses. Holding `cmp_i` high for many clocks counts as a single pulse.
- R4: While the flag is high, a spacing of at most GAP_CLKS clocks between successive rising edges keeps it high. With no edge within GAP_CLKS clocks of the last one, the flag falls SYNC_STAGES+GAP_CLKS+1 clocks after that last edge.
- R5: If the window expires before a run is complete, the partial count is discarded, and PULSE_RUN new edges are needed.
- R6: After the flag has fallen, it rises again only after PULSE_RUN new consecutive edges.
- R7: While `rts_n_i` is low, the flag is low in the same cycle and edges are not counted. After `rts_n_i` returns high, counting starts from zero.
- R8: A low pulse on `rts_n_i` in the middle of a run discards the partial count.
- R9: A reset in the middle of a run discards the partial count, so PULSE_RUN edges after reset are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock (460.8 kHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_i | input | 1 | Comparator output, high when the receive signal is above threshold; asynchronous |
| rts_n_i | input | 1 | Request-to-send, active low; low means the local side transmits |
| cd_o | output | 1 | Carrier-detect flag, high while a valid carrier is present |

## Verification
The bench builds the block with its default parameters: GAP_CLKS of 1152, PULSE_RUN of 4 and SYNC_STAGES of 2. The pulse trains therefore use the true tone spacings of 384 and 209 clocks. The window boundary is tested with a spacing of exactly 1152 clocks against one of 1153, and with a 1209-clock gap in the middle of a run. Because the window is only about a thousand clocks, every scenario fits in a few tens of thousands of cycles. Each scheduled expectation names the clock in which the flag must hold a given value, so both the assertion latency and the drop latency are checked to the cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;

    // Control states of the carrier detector.
    typedef enum logic [1:0] {
        CS_TX     = 2'd0,   // local side transmitting, detector held quiet
        CS_IDLE   = 2'd1,   // no pulses collected
        CS_GATHER = 2'd2,   // collecting a run of consecutive pulses
        CS_LOCK   = 2'd3    // carrier present, flag high
    } cs_state_e;

endpackage

// File: rtl/cs_edge_sync.sv
module cs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= raw_i;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~prev;

    // A held-high level yields one pulse, never two in a row.
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
    parameter int GAP_CLKS = 1152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);

    localparam int          W    = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
    localparam logic [W-1:0] LAST = W'(GAP_CLKS - 1);

    logic [W-1:0] cnt;

    // Counts clocks since the last pulse; holds at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) cnt <= '0;
        else if (cnt != LAST)              cnt <= cnt + 1'b1;
    end

    assign expire_o = run_i && !restart_i && (cnt == LAST);

endmodule

// File: rtl/cs_run_counter.sv
module cs_run_counter #(
    parameter int PULSE_RUN = 4
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           clr_i,
    input  logic                                           inc_i,
    output logic [((PULSE_RUN > 2) ? $clog2(PULSE_RUN) : 1)-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_o <= '0;
        else if (inc_i)      cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/carrier_sense.sv
module carrier_sense
    import cs_pkg::*;
#(
    parameter int GAP_CLKS    = 1152,
    parameter int PULSE_RUN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    input  logic rts_n_i,
    output logic cd_o
);

    localparam int            RW       = (PULSE_RUN > 2) ? $clog2(PULSE_RUN) : 1;
    localparam logic [RW-1:0] LAST_RUN = RW'(PULSE_RUN - 1);

    cs_state_e     state;
    cs_state_e     state_nx;
    logic          rise;
    logic          expire;
    logic          timing;
    logic [RW-1:0] run_cnt;

    cs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (cmp_i),
        .rise_o (rise)
    );

    assign timing = (state == CS_GATHER) || (state == CS_LOCK);

    cs_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timing),
        .restart_i (rise),
        .expire_o  (expire)
    );

    cs_run_counter #(.PULSE_RUN(PULSE_RUN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_nx != CS_GATHER),
        .inc_i (rise),
        .cnt_o (run_cnt)
    );

    // Next-state selection.
    always_comb begin
        state_nx = state;
        if (!rts_n_i) begin
            state_nx = CS_TX;
        end else begin
            unique case (state)
                CS_TX:     state_nx = CS_IDLE;
                CS_IDLE:   if (rise) state_nx = CS_GATHER;
                CS_GATHER: begin
                    if (rise && run_cnt == LAST_RUN) state_nx = CS_LOCK;
                    else if (expire)                 state_nx = CS_IDLE;
                end
                CS_LOCK:   if (expire) state_nx = CS_IDLE;
                default:   state_nx = CS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CS_IDLE;
        else        state <= state_nx;
    end

    // Output: flag gated directly by request-to-send.
    always_comb begin
        cd_o = (state == CS_LOCK) && rts_n_i;
    end

    // Reset empties the run and lowers the flag.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (state == CS_IDLE && run_cnt == '0 && !cd_o));

    // The flag only rises on the edge that completes a run.
    assert_lock_on_last_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_o) |-> ($past(rise) && $past(run_cnt) == LAST_RUN));

    // A window expiry while locked drops the flag.
    assert_gap_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_LOCK && expire) |=> !cd_o);

    // A window expiry during a partial run discards its count.
    assert_stale_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_GATHER && expire) |=> (run_cnt == '0));

    // Transmit request parks the machine.
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_n_i |=> (state == CS_TX && run_cnt == '0));

endmodule

// File: tb/test_carrier_sense.sv
`timescale 1ns/1ps
module test_carrier_sense;

    localparam int GAP  = 1152;
    localparam int RUN  = 4;
    localparam int LAT  = 2;     // synchronizer stages
    localparam int LOW  = 0;     // burst ends with flag low
    localparam int RISE = 1;     // burst's last edge raises flag

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp = 1'b0;
    logic rts_n = 1'b1;
    logic cd;

    int unsigned cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int unsigned at;
        bit          val;
        string       tag;
    } exp_t;

    exp_t q[$];

    carrier_sense #(.GAP_CLKS(GAP), .PULSE_RUN(RUN), .SYNC_STAGES(LAT)) i_carrier_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_i   (cmp),
        .rts_n_i (rts_n),
        .cd_o    (cd)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: schedule an expected flag value dt clocks from now.
    task automatic want(input int unsigned dt, input bit v, input string tag);
        exp_t e;
        e.at  = cyc + dt;
        e.val = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        cmp = 1'b1;
        idle(hi);
        cmp = 1'b0;
        idle(lo);
    endtask

    // n pulses of the given spacing; tail extends the last low phase.
    task automatic burst(input int n, input int period, input int tail,
                         input int mode, input string tag);
        for (int k = 0; k < n; k++) begin
            if (k == n - 1) begin
                if (mode == RISE) begin
                    want(LAT, 1'b0, tag);
                    want(LAT + 1, 1'b1, tag);
                end else begin
                    want(LAT + 1, 1'b0, tag);
                end
            end
            pulse(period / 2, period - period / 2 + ((k == n - 1) ? tail : 0));
        end
    endtask

    // Monitor: pop expectations as their clock arrives and compare.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (e.at != cyc) begin
                    n_fail++;
                    $display("FAIL %s: expectation for cycle %0d seen at cycle %0d (actual %b, expected %b)",
                             e.tag, e.at, cyc, cd, e.val);
                end else if (cd !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: cycle %0d cd_o actual %b expected %b", e.tag, cyc, cd, e.val);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        want(1, 1'b0, "R1");
        idle(5);
        rst_n = 1'b1;
        idle(10);

        // R2: run at 1200 Hz spacing, exact latency
        burst(3, 384, 0, LOW, "R2");
        burst(1, 384, 0, RISE, "R2");

        // R4: spacing of exactly GAP keeps the flag, GAP+1 drops it
        want(GAP + LAT + 1, 1'b1, "R4");
        pulse(10, GAP - 10);
        want(GAP + LAT, 1'b1, "R4");
        want(GAP + LAT + 1, 1'b0, "R4");
        pulse(10, GAP + 1 - 10 + 2000);

        // R6: four fresh edges at 2200 Hz spacing re-arm it
        want(1, 1'b0, "R6");
        burst(3, 209, 0, LOW, "R6");
        burst(1, 209, 2000, RISE, "R6");

        // R5: three edges, window expires, stale count discarded
        burst(3, 209, 1000, LOW, "R5");
        burst(3, 209, 0, LOW, "R5");
        burst(1, 209, 2000, RISE, "R5");

        // R3: a long high level counts as one pulse
        pulse(1000, 100);
        burst(2, 209, 0, LOW, "R3");
        burst(1, 209, 0, RISE, "R3");

        // R7: transmit forces the flag low at once and blocks counting
        want(0, 1'b0, "R7");
        rts_n = 1'b0;
        burst(5, 209, 50, LOW, "R7");
        rts_n = 1'b1;
        idle(20);
        burst(3, 209, 0, LOW, "R7");
        burst(1, 209, 0, RISE, "R7");

        // R8: a brief transmit request mid-run discards the count
        rts_n = 1'b0;
        idle(5);
        rts_n = 1'b1;
        idle(5);
        burst(3, 209, 0, LOW, "R8");
        rts_n = 1'b0;
        idle(3);
        rts_n = 1'b1;
        burst(1, 209, 0, LOW, "R8");
        burst(2, 209, 0, LOW, "R8");
        burst(1, 209, 0, RISE, "R8");

        // R9 / R1: reset while locked, then reset mid-run
        want(1, 1'b0, "R1");
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(5);
        burst(3, 209, 0, LOW, "R9");
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        burst(1, 209, 0, LOW, "R9");
        burst(2, 209, 0, LOW, "R9");
        burst(1, 209, 0, RISE, "R9");

        idle(20);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d expectations left (actual %0d, expected 0)", q.size(), q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule